// File: doc/BRIEF.md
# Sequential Burst Boundary Splitter

This block takes multi-word transfer requests from a processor core and turns each one into the bursts or single accesses that a burst-capable bus master issues. A request carries a start address, a word count, a direction and two region attributes: cacheable and bufferable. Loads to non-cacheable memory go out as sequential bursts, whether or not the region is bufferable. Stores to memory that is both non-cacheable and non-bufferable also go out as sequential bursts. Every other request is broken into single-word accesses.

No sequential burst that leaves the block spans a boundary of `BOUND_BYTES` bytes (1 KB by default). When a request would cross such a boundary, it is cut exactly at the boundary. A page-mode memory controller downstream, with a page size of at least the boundary size, can therefore treat every sequential beat as a hit in the same page.

Both sides use valid/ready. Each request is held until the whole of it has been handed on. While that is happening, `req_ready` stays low, so the request side feels the back-pressure. On the output side, an item with `bst_valid` high and `bst_ready` low keeps its address, length and flags unchanged until it is taken. The block handles addresses only; it moves no data.

Top module: `bsplit_top`

## Requirements
- R1: After reset, `bst_valid` and `req_reject` are low and `req_ready` is high.
- R2: `req_ready` is high only while no accepted request still has items to hand on. The first item of an accepted request appears with `bst_valid` high in the cycle after acceptance.
- R3: A load (`req_write`=0) with `req_cacheable`=0 is issued as sequential bursts with `bst_seq`=1, whatever the value of `req_bufferable`.
- R4: A store (`req_write`=1) with `req_cacheable`=0 and `req_bufferable`=0 is issued as sequential bursts with `bst_seq`=1.
- R5: Any other request is issued as `req_words` single items. Each has `bst_len`=1 and `bst_seq`=0, and their addresses rise by 4 bytes per item.
- R6: The start address plus the length of a burst never crosses a `BOUND_BYTES` boundary. Each burst's length is the smaller of two values: the words still to transfer, and the words left before the next boundary. The following burst starts exactly on that boundary.
- R7: While `bst_valid` is high and `bst_ready` is low, `bst_valid`, `bst_addr`, `bst_len`, `bst_seq` and `bst_write` stay unchanged on the next cycle.
- R8: A request with `req_words` equal to 0 or greater than `MAX_WORDS` is rejected. It is consumed, and `req_reject` is high for exactly the cycle after acceptance. It produces no output item.
- R9: The items of a request come out in ascending address order. Their lengths sum to `req_words`, `bst_write` copies `req_write`, and `bst_len` lies between 1 and `MAX_WORDS`.
- R10: Address bits [1:0] are ignored. `bst_addr[1:0]` is always 0 and the first item starts at the word that holds `req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Start byte address |
| req_words | input | CNT_W | Word count, 1..MAX_WORDS is legal |
| req_write | input | 1 | 1 = store, 0 = load |
| req_cacheable | input | 1 | Region is cacheable |
| req_bufferable | input | 1 | Region is bufferable |
| req_reject | output | 1 | Pulse: the last accepted request had an illegal count |
| bst_valid | output | 1 | Output item offered |
| bst_ready | input | 1 | Output item taken |
| bst_addr | output | ADDR_W | Item start byte address, word aligned |
| bst_len | output | CNT_W | Item length in words |
| bst_seq | output | 1 | 1 = sequential burst, 0 = single access |
| bst_write | output | 1 | Item direction |

## Verification
The bench builds the block with `BOUND_BYTES`=64 (16 words), `MAX_WORDS`=16 and `ADDR_W`=16. With those values a single 16-word request can land on any word offset inside a boundary window. That covers the exact-fit case, the one-word-then-fifteen split, and aligned requests that need no split, all within a short run. It also lets a request of the largest legal length straddle a boundary. Back-pressure from a pseudo-random `bst_ready` exercises the hold rule and the acceptance stall on every kind of request.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_BURST  = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/bsplit_class.sv
module bsplit_class
  import bsplit_pkg::*;
(
  input  logic       is_write,
  input  logic       cacheable,
  input  logic       bufferable,
  output xfer_mode_e mode
);
  // Non-cacheable loads and non-cacheable non-bufferable stores go out as bursts.
  always_comb begin
    if (!cacheable && (!is_write || !bufferable)) mode = MODE_BURST;
    else                                          mode = MODE_SINGLE;
  end
endmodule

// File: rtl/bsplit_room.sv
module bsplit_room #(
  parameter int ADDR_W      = 32,
  parameter int BOUND_BYTES = 1024,
  localparam int BLOG       = $clog2(BOUND_BYTES),
  localparam int ROOM_W     = BLOG - 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROOM_W-1:0] room
);
  localparam int BOUND_WORDS = BOUND_BYTES / 4;
  localparam logic [ROOM_W-1:0] FULL = ROOM_W'(BOUND_WORDS);

  logic [BLOG-3:0] offset;
  assign offset = addr[BLOG-1:2];
  assign room   = FULL - {1'b0, offset};
endmodule

// File: rtl/bsplit_cursor.sv
module bsplit_cursor
  import bsplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5,
  parameter int ROOM_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drop,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              load_write,
  input  xfer_mode_e        load_mode,
  input  logic              take,
  input  logic [ROOM_W-1:0] room,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_len,
  output logic              cur_write,
  output xfer_mode_e        cur_mode,
  output logic              reject
);
  localparam int LW = CNT_W + ROOM_W;

  logic [CNT_W-1:0] rem;
  logic [LW-1:0]    rem_x, room_x, pick;

  assign rem_x  = {{ROOM_W{1'b0}}, rem};
  assign room_x = {{CNT_W{1'b0}}, room};

  always_comb begin
    if (cur_mode == MODE_BURST) pick = (rem_x < room_x) ? rem_x : room_x;
    else                        pick = LW'(1);
  end
  assign cur_len = pick[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur_addr  <= '0;
      rem       <= '0;
      cur_write <= 1'b0;
      cur_mode  <= MODE_SINGLE;
      reject    <= 1'b0;
    end else begin
      reject <= drop;
      if (load) begin
        busy      <= 1'b1;
        cur_addr  <= {load_addr[ADDR_W-1:2], 2'b00};
        rem       <= load_cnt;
        cur_write <= load_write;
        cur_mode  <= load_mode;
      end else if (take) begin
        cur_addr <= cur_addr + {{(ADDR_W-CNT_W-2){1'b0}}, cur_len, 2'b00};
        rem      <= rem - cur_len;
        if (rem == cur_len) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bsplit_top.sv
module bsplit_top
  import bsplit_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_WORDS   = 16,
  parameter int BOUND_BYTES = 1024,
  localparam int CNT_W      = $clog2(MAX_WORDS + 1),
  localparam int ROOM_W     = $clog2(BOUND_BYTES) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_words,
  input  logic              req_write,
  input  logic              req_cacheable,
  input  logic              req_bufferable,
  output logic              req_reject,
  output logic              bst_valid,
  input  logic              bst_ready,
  output logic [ADDR_W-1:0] bst_addr,
  output logic [CNT_W-1:0]  bst_len,
  output logic              bst_seq,
  output logic              bst_write
);
  xfer_mode_e        in_mode, cur_mode;
  logic              busy, accept, legal;
  logic [ROOM_W-1:0] room;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign legal     = (req_words != '0) && (req_words <= CNT_W'(MAX_WORDS));

  bsplit_class u_class (
    .is_write  (req_write),
    .cacheable (req_cacheable),
    .bufferable(req_bufferable),
    .mode      (in_mode)
  );

  bsplit_room #(.ADDR_W(ADDR_W), .BOUND_BYTES(BOUND_BYTES)) u_room (
    .addr(bst_addr),
    .room(room)
  );

  bsplit_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ROOM_W(ROOM_W)) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && legal),
    .drop      (accept && !legal),
    .load_addr (req_addr),
    .load_cnt  (req_words),
    .load_write(req_write),
    .load_mode (in_mode),
    .take      (bst_valid && bst_ready),
    .room      (room),
    .busy      (busy),
    .cur_addr  (bst_addr),
    .cur_len   (bst_len),
    .cur_write (bst_write),
    .cur_mode  (cur_mode),
    .reject    (req_reject)
  );

  assign bst_valid = busy;
  assign bst_seq   = (cur_mode == MODE_BURST);
endmodule

// File: rtl/bsplit_chk.sv
module bsplit_chk #(
  parameter int ADDR_W      = 32,
  parameter int MAX_WORDS   = 16,
  parameter int BOUND_BYTES = 1024,
  parameter int CNT_W       = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CNT_W-1:0]  req_words,
  input logic              req_reject,
  input logic              bst_valid,
  input logic              bst_ready,
  input logic [ADDR_W-1:0] bst_addr,
  input logic [CNT_W-1:0]  bst_len,
  input logic              bst_seq,
  input logic              bst_write
);
  localparam int BLOG = $clog2(BOUND_BYTES);
  localparam int EW   = BLOG + CNT_W;

  logic [EW-1:0] end_word;
  assign end_word = EW'(bst_addr[BLOG-1:2]) + EW'(bst_len);

  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> end_word <= EW'(BOUND_BYTES / 4)); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid && !bst_ready |=> bst_valid && $stable(bst_addr) && $stable(bst_len)
      && $stable(bst_seq) && $stable(bst_write)); // R7

  AST_SINGLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid && !bst_seq |-> bst_len == CNT_W'(1)); // R5

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> bst_len != '0 && bst_len <= CNT_W'(MAX_WORDS)); // R9

  AST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> bst_addr[1:0] == 2'b00); // R10

  AST_STALL_IN: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> !req_ready); // R2

  AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_words == '0 || req_words > CNT_W'(MAX_WORDS))
      |=> req_reject && !bst_valid); // R8
endmodule

bind bsplit_top bsplit_chk #(
  .ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS), .BOUND_BYTES(BOUND_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_words(req_words), .req_reject(req_reject), .bst_valid(bst_valid),
  .bst_ready(bst_ready), .bst_addr(bst_addr), .bst_len(bst_len),
  .bst_seq(bst_seq), .bst_write(bst_write)
);

// File: tb/sim_bsplit_top.sv
module sim_bsplit_top;
  localparam int AW  = 16;
  localparam int MW  = 16;
  localparam int BB  = 64;
  localparam int CW  = $clog2(MW + 1);
  localparam int BWD = BB / 4;
  localparam int IW  = AW + CW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_cacheable = 1'b0, req_bufferable = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_words = '0;
  logic          bst_ready = 1'b0;
  logic          req_ready, req_reject, bst_valid, bst_seq, bst_write;
  logic [AW-1:0] bst_addr;
  logic [CW-1:0] bst_len;

  int checks = 0;
  int fails  = 0;
  logic [IW-1:0] expq[$];
  logic [7:0] lfsr = 8'hA5;

  always #10 clk = ~clk;

  bsplit_top #(.ADDR_W(AW), .MAX_WORDS(MW), .BOUND_BYTES(BB)) u0 (.*);

  task automatic note(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: predicts the items from the requirements, then offers the request.
  task automatic send(input int addr, input int cnt, input bit wr, input bit ca, input bit bu);
    int w;
    int left;
    bit burst;
    burst = !ca && (!wr || !bu); // R3, R4
    w = addr >> 2;               // R10
    left = cnt;
    if (cnt >= 1 && cnt <= MW) begin
      while (left > 0) begin
        int room, len;
        room = BWD - (w % BWD);
        len  = burst ? ((left < room) ? left : room) : 1; // R5, R6
        expq.push_back({AW'(w << 2), CW'(len), burst, wr});
        w += len;
        left -= len;
      end
    end
    while (!req_ready) @(negedge clk);
    req_addr = AW'(addr); req_words = CW'(cnt); req_write = wr;
    req_cacheable = ca; req_bufferable = bu; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (cnt == 0 || cnt > MW) begin
      note(req_reject == 1'b1, "R8", "reject pulse", req_reject, 1);
      note(bst_valid == 1'b0, "R8", "no item after reject", bst_valid, 0);
      @(negedge clk);
      note(req_reject == 1'b0, "R8", "reject lasts one cycle", req_reject, 0);
    end else begin
      note(bst_valid == 1'b1, "R2", "item the cycle after acceptance", bst_valid, 1);
    end
  endtask

  // Ready pattern, changed away from both edges.
  initial forever begin
    @(posedge clk);
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bst_ready = lfsr[0] | lfsr[2];
  end

  // Monitor: pops and compares each item as it is taken.
  initial begin
    logic          stall = 1'b0;
    logic [IW-1:0] prev = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stall) // R7
          note(bst_valid && {bst_addr, bst_len, bst_seq, bst_write} == prev, "R7",
               "hold under back-pressure", {bst_addr, bst_len, bst_seq, bst_write}, prev);
        if (bst_valid && bst_ready) begin
          if (expq.size() == 0) begin
            note(1'b0, "R9", "unexpected item", {bst_addr, bst_len}, 0);
          end else begin
            logic [IW-1:0] e;
            e = expq.pop_front();
            note({bst_addr, bst_len, bst_seq, bst_write} == e, e[1] ? "R6" : "R5",
                 "item", {bst_addr, bst_len, bst_seq, bst_write}, e);
          end
        end
        stall = bst_valid && !bst_ready;
        prev  = {bst_addr, bst_len, bst_seq, bst_write};
      end
    end
  end

  initial begin
    #(20 * 150000);
    note(1'b0, "R2", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    note(bst_valid == 1'b0 && req_reject == 1'b0 && req_ready == 1'b1, "R1", "reset state",
         {bst_valid, req_reject, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    note(bst_valid == 1'b0 && req_ready == 1'b1, "R1", "idle after reset",
         {bst_valid, req_ready}, 2'b01);
    send('h0010, 8, 0, 0, 0);   // R3 fits in window
    send('h0030, 8, 0, 0, 1);   // R3 bufferable load, split 4 + 4
    send('h0040, 16, 1, 0, 0);  // R4 aligned full window
    send('h007C, 16, 1, 0, 0);  // R4 R6 split 1 + 15
    send('h0038, 3, 1, 0, 1);   // R5 bufferable store, singles across boundary
    send('h0100, 2, 0, 1, 0);   // R5 cacheable load
    send('h0020, 0, 0, 0, 0);   // R8 zero
    send('h0020, 17, 1, 0, 0);  // R8 too long
    send('h0013, 2, 0, 0, 0);   // R10 low bits ignored
    send('h00F0, 16, 0, 0, 0);  // R6 split 4 + 12
    send('h00BC, 16, 1, 0, 0);  // R9 split 1 + 15
    for (int i = 0; i < 60; i++) begin
      send((i * 148 + 12) & 'hFFFF, (i * 7) % 18, i[0], i[2] & i[3], i[1]);
    end
    for (int i = 0; i < 2000 && expq.size() != 0; i++) @(negedge clk);
    note(expq.size() == 0, "R9", "all items issued", expq.size(), 0);
    repeat (3) @(negedge clk);
    note(bst_valid == 1'b0 && req_ready == 1'b1, "R2", "idle after drain",
         {bst_valid, req_ready}, 2'b01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule